// File: doc/BRIEF.md
# Adaptive Coherence Granularity Tracker

This block sits beside a coherence directory and chooses, region by region, how finely sharing is recorded. A region is a 512-byte aligned block made of eight 64-byte lines. By default a region is in fine mode, where the directory keeps one entry per line. When a region is read by enough different cores and has never been written while tracked, the tracker promotes it to coarse mode, where the directory keeps a single entry for all eight lines. A write to a coarse region demotes it at once.

The tracker watches every request the directory receives (read or write, requesting core, byte address). It keeps a small fully associative history table with least-recently-used replacement. When a coarse region loses its table slot it falls back to fine mode. The directory asks for the current mode of an address on a separate lookup port and gets the answer one cycle later. The block pulses a merge event when a region becomes coarse and a split event when it becomes fine again. The directory uses these events to combine or expand its sharer entries before it services the request that caused them.

Top module: `gran_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every region is in fine mode, `lk_coarse`, `split_evt` and `merge_evt` are 0, and all history is discarded.
- R2: `lk_coarse` is 1 in the cycle after a lookup (`lk_valid`=1) whose region (address bits above bit 8) is tracked in coarse mode. It is 0 in every other cycle, and the low nine address bits have no effect on it.
- R3: A read (`req_write`=0) promotes a fine, never-written tracked region once the number of distinct requesting cores recorded for it reaches `PROMOTE_THRESH` (default 4). In the next cycle `merge_evt` is 1 and `evt_region` holds that region.
- R4: Repeated reads from a core already recorded for a region do not raise its distinct-reader count.
- R5: A write (`req_write`=1) to a fine region marks the region as written. A written region is never promoted while it stays in the table, and no `merge_evt` follows a write request.
- R6: A write to a coarse region demotes it to fine at once. In the next cycle `split_evt` is 1 and `evt_region` holds the region, and the region counts as written.
- R7: The table holds `ENTRIES` (default 16) regions. A request to an untracked region evicts the least recently requested one when the table is full. If the evicted region was coarse, `split_evt` is 1 in the next cycle with `evt_region` set to it. A re-allocated region starts with empty history.
- R8: A lookup of a region that is not tracked returns fine (0).
- R9: A lookup presented in the same cycle as a request sees the table as it was before that request.
- R10: `split_evt` and `merge_evt` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A coherence request is presented |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_core | input | CORE_W (4) | Requesting core number |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| lk_valid | input | 1 | Mode lookup is presented |
| lk_addr | input | ADDR_W (32) | Byte address to look up |
| lk_coarse | output | 1 | Looked-up region is coarse (one cycle later) |
| split_evt | output | 1 | A region went from coarse to fine |
| merge_evt | output | 1 | A region went from fine to coarse |
| evt_region | output | ADDR_W-9 (23) | Region number of the latest event |

## Verification
Wrong internal state shows up at the ports. A lost or corrupted reader set shows as a merge event that comes one read too early or too late. A stale coarse flag shows as a wrong `lk_coarse` on the next lookup, one cycle later. A wrong recency order appears only when the table fills: the wrong region is evicted, so a split event carries the wrong region number, or a region that should have been dropped is still reported as coarse. Because of this, the stimulus keeps the table full and issues lookups throughout, so a recency fault shows within a few requests after it happens.

// File: rtl/gt_pkg.sv
`timescale 1ns/1ps
package gt_pkg;
   // kind of mode change produced by one request
   typedef enum logic [1:0] {
      GT_EV_NONE  = 2'd0,
      GT_EV_SPLIT = 2'd1,
      GT_EV_MERGE = 2'd2
   } gt_evt_e;

   // number of set bits in a sharer vector (up to 64 cores)
   function automatic int unsigned gt_popcnt(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/gt_match.sv
`timescale 1ns/1ps
module gt_match #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 23,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);
   logic [ENTRIES-1:0] eq;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == key);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/gt_lru.sv
`timescale 1ns/1ps
module gt_lru #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic [ENTRIES-1:0] valid,
   output logic [IDX_W-1:0]   victim_idx
);
   // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
   logic [ENTRIES-1:0][IDX_W-1:0] age_q;
   logic [IDX_W-1:0]              oldest_idx, free_idx;
   logic                          any_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_idx = '0;
      free_idx   = '0;
      any_free   = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
         if (!valid[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
   end

   assign victim_idx = any_free ? free_idx : oldest_idx;
endmodule

// File: rtl/gran_tracker.sv
`timescale 1ns/1ps
module gran_tracker #(
   parameter int ADDR_W         = 32,
   parameter int LINE_LOG2      = 6,
   parameter int GROUP_LOG2     = 3,
   parameter int CORES          = 16,
   parameter int ENTRIES        = 16,
   parameter int PROMOTE_THRESH = 4,
   localparam int OFF_W  = LINE_LOG2 + GROUP_LOG2,
   localparam int REG_W  = ADDR_W - OFF_W,
   localparam int CORE_W = (CORES > 1) ? $clog2(CORES) : 1,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CORE_W-1:0] req_core,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_coarse,
   output logic              split_evt,
   output logic              merge_evt,
   output logic [REG_W-1:0]  evt_region
);
   import gt_pkg::*;

   // elaboration-time parameter checks
   if (PROMOTE_THRESH < 2 || PROMOTE_THRESH > CORES) begin : g_bad_thresh
      $error("PROMOTE_THRESH must lie in 2..CORES");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (CORES > 64 || REG_W < 1) begin : g_bad_size
      $error("CORES must not exceed 64 and ADDR_W must exceed the region offset");
   end

   // table state
   logic [ENTRIES-1:0]            vld_q, crs_q, wr_q;
   logic [ENTRIES-1:0][REG_W-1:0] tag_q;
   logic [ENTRIES-1:0][CORES-1:0] shr_q;

   logic [REG_W-1:0] rq_reg, lk_reg;
   logic             rq_hit, lk_hit;
   logic [IDX_W-1:0] rq_idx, lk_idx, victim, slot;

   assign rq_reg = req_addr[ADDR_W-1:OFF_W];
   assign lk_reg = lk_addr[ADDR_W-1:OFF_W];

   gt_match #(.ENTRIES(ENTRIES), .TAG_W(REG_W)) u_rq_match (
      .valid(vld_q), .tags(tag_q), .key(rq_reg), .hit(rq_hit), .hit_idx(rq_idx));

   gt_match #(.ENTRIES(ENTRIES), .TAG_W(REG_W)) u_lk_match (
      .valid(vld_q), .tags(tag_q), .key(lk_reg), .hit(lk_hit), .hit_idx(lk_idx));

   gt_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch(req_valid), .touch_idx(slot),
      .valid(vld_q), .victim_idx(victim));

   assign slot = rq_hit ? rq_idx : victim;

   // next history of the addressed slot
   logic [CORES-1:0] core_bit, nxt_shr;
   logic             nxt_wr, was_crs, nxt_crs, evict_split;
   logic [63:0]      shr_wide;
   gt_evt_e          ev_kind;

   assign core_bit = CORES'(1) << req_core;

   always_comb begin
      was_crs     = rq_hit && crs_q[slot];
      nxt_shr     = (rq_hit ? shr_q[slot] : '0) | (req_write ? '0 : core_bit);
      nxt_wr      = (rq_hit && wr_q[slot]) || req_write;
      shr_wide    = 64'(nxt_shr);
      evict_split = !rq_hit && vld_q[slot] && crs_q[slot];
      ev_kind     = GT_EV_NONE;
      nxt_crs     = was_crs && !req_write;
      if (req_valid) begin
         if ((was_crs && req_write) || evict_split) begin
            ev_kind = GT_EV_SPLIT;
         end else if (!req_write && !nxt_wr && !was_crs &&
                      gt_popcnt(shr_wide) >= PROMOTE_THRESH) begin
            ev_kind = GT_EV_MERGE;
            nxt_crs = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         crs_q <= '0;
         wr_q  <= '0;
         tag_q <= '0;
         shr_q <= '0;
      end else if (req_valid) begin
         vld_q[slot] <= 1'b1;
         tag_q[slot] <= rq_reg;
         shr_q[slot] <= nxt_shr;
         wr_q[slot]  <= nxt_wr;
         crs_q[slot] <= nxt_crs;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_coarse  <= 1'b0;
         split_evt  <= 1'b0;
         merge_evt  <= 1'b0;
         evt_region <= '0;
      end else begin
         lk_coarse <= lk_valid && lk_hit && crs_q[lk_idx];
         split_evt <= (ev_kind == GT_EV_SPLIT);
         merge_evt <= (ev_kind == GT_EV_MERGE);
         if (ev_kind != GT_EV_NONE) evt_region <= evict_split ? tag_q[slot] : rq_reg;
      end
   end
endmodule

// File: rtl/gran_tracker_chk.sv
`timescale 1ns/1ps
module gran_tracker_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 9,
   localparam int REG_W = ADDR_W - OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              lk_valid,
   input logic              lk_coarse,
   input logic              split_evt,
   input logic              merge_evt,
   input logic [REG_W-1:0]  evt_region
);
   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!lk_coarse && !split_evt && !merge_evt);
      end
   end

   assert_lookup_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lk_valid) |-> !lk_coarse);

   assert_merge_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      merge_evt |-> $past(req_valid && !req_write));

   assert_merge_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
      merge_evt |-> evt_region == $past(req_addr[ADDR_W-1:OFF_W]));

   assert_no_merge_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_write) |-> !merge_evt);

   assert_split_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      split_evt |-> $past(req_valid));

   assert_evt_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(split_evt && merge_evt));
endmodule

bind gran_tracker gran_tracker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .lk_valid(lk_valid), .lk_coarse(lk_coarse),
   .split_evt(split_evt), .merge_evt(merge_evt), .evt_region(evt_region));

// File: tb/gran_tracker_bench.sv
`timescale 1ns/1ps
module gran_tracker_bench;
   localparam int ADDR_W = 32;
   localparam int REG_W  = 23;
   localparam int NENT   = 16;
   localparam int THR    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, lk_valid = 1'b0;
   logic [3:0]  req_core = '0;
   logic [31:0] req_addr = '0, lk_addr = '0;
   logic        lk_coarse, split_evt, merge_evt;
   logic [REG_W-1:0] evt_region;

   always #5 clk = ~clk;

   gran_tracker u_gran_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_core(req_core), .req_addr(req_addr), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_coarse(lk_coarse), .split_evt(split_evt), .merge_evt(merge_evt),
      .evt_region(evt_region));

   int total = 0, bad = 0;
   bit done = 0;

   // behavioural reference: per-region history plus recency queue (front = newest)
   logic [15:0] m_shr [int];
   bit          m_wr  [int];
   bit          m_crs [int];
   int          order [$];

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int popc(input logic [15:0] v);
      int n = 0;
      for (int i = 0; i < 16; i++) n += int'(v[i]);
      return n;
   endfunction

   // one cycle: present inputs, predict, clock, compare
   task automatic step(input string tag, input bit rv, input bit rw, input int core,
                       input int raddr, input bit lv, input int laddr);
      bit e_lk = 0, e_sp = 0, e_mg = 0;
      int e_reg = 0;
      int r;
      req_valid = rv; req_write = rw; req_core = 4'(core); req_addr = 32'(raddr);
      lk_valid = lv; lk_addr = 32'(laddr);
      if (lv) begin
         r = laddr >>> 9;
         e_lk = m_crs.exists(r) && m_crs[r];   // pre-request table (R9)
      end
      if (rv) begin
         r = raddr >>> 9;
         if (m_crs.exists(r)) begin
            foreach (order[i]) if (order[i] == r) begin order.delete(i); break; end
         end else begin
            if (order.size() == NENT) begin
               int v = order.pop_back();
               if (m_crs[v]) begin e_sp = 1; e_reg = v; end
               m_shr.delete(v); m_wr.delete(v); m_crs.delete(v);
            end
            m_shr[r] = '0; m_wr[r] = 0; m_crs[r] = 0;
         end
         order.push_front(r);
         if (rw) begin
            if (m_crs[r]) begin e_sp = 1; e_reg = r; m_crs[r] = 0; end
            m_wr[r] = 1;
         end else begin
            m_shr[r] |= 16'(1) << core;
            if (!m_crs[r] && !m_wr[r] && popc(m_shr[r]) >= THR) begin
               m_crs[r] = 1; e_mg = 1; e_reg = r;
            end
         end
      end
      @(posedge clk); #1;
      check({tag, " lk_coarse (R2)"}, lk_coarse, e_lk);
      check({tag, " split_evt (R6/R7)"}, split_evt, e_sp);
      check({tag, " merge_evt (R3)"}, merge_evt, e_mg);
      check("R10 exclusive events", int'(split_evt && merge_evt), 0);
      if (e_sp || e_mg) check({tag, " evt_region"}, evt_region, e_reg);
      req_valid = 0; lk_valid = 0;
   endtask

   task automatic rd(input string tag, input int core, input int a);
      step(tag, 1, 0, core, a, 0, 0);
   endtask
   task automatic wrt(input string tag, input int core, input int a);
      step(tag, 1, 1, core, a, 0, 0);
   endtask
   task automatic look(input string tag, input int a);
      step(tag, 0, 0, 0, 0, 1, a);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int a, b, c, d;
      // R1: outputs quiet during and just after reset
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset lk_coarse", lk_coarse, 0);
      check("R1 reset split_evt", split_evt, 0);
      check("R1 reset merge_evt", merge_evt, 0);
      rst_n = 1;
      @(posedge clk); #1;
      look("R8 untracked lookup", 32'h0001_2340);

      // R3/R4: promotion after four distinct readers, repeat readers ignored
      a = 32'h0000_4000;
      rd("R3 reader0", 0, a + 8'h00);
      rd("R3 reader1", 1, a + 8'h40);
      rd("R3 reader2", 2, a + 9'h1c0);
      rd("R4 repeat reader1", 1, a + 8'h80);
      rd("R4 repeat reader0", 0, a);
      look("R3 still fine", a);
      rd("R3 reader3 promotes", 3, a + 8'hc0);
      look("R2 coarse lookup", a);
      look("R2 offset ignored", a + 9'h1ff);
      rd("R3 read on coarse", 9, a);

      // R6: write to a coarse region splits it
      wrt("R6 write splits", 5, a + 8'h40);
      look("R6 now fine", a);
      rd("R5 reader after write", 6, a);
      rd("R5 reader after write", 7, a);

      // R5: written region never promotes
      b = 32'h0010_0000;
      wrt("R5 first write", 2, b);
      for (int k = 0; k < 8; k++) rd("R5 readers after write", k, b + k * 64);
      look("R5 stays fine", b);

      // R9: lookup alongside the promoting read sees old state
      c = 32'h0020_0000;
      for (int k = 0; k < 3; k++) rd("R9 setup", k + 4, c);
      step("R9 same-cycle lookup", 1, 0, 12, c, 1, c);
      look("R9 after", c);

      // R7: eviction of a coarse region
      d = 32'h0030_0000;
      for (int k = 0; k < 4; k++) rd("R7 promote", k, d);
      for (int k = 0; k < NENT; k++) rd("R7 fill", 0, 32'h0100_0000 + k * 512);
      look("R7 evicted is fine", d);
      for (int k = 0; k < 3; k++) rd("R7 fresh history", k + 8, d);
      look("R7 fresh not coarse", d);
      rd("R7 fourth new reader", 15, d);
      look("R7 coarse again", d);

      // mixed traffic over a pool larger than the table
      for (int n = 0; n < 3000; n++) begin
         int ra = (($urandom % 20) << 9) | ($urandom % 512);
         int la = (($urandom % 20) << 9) | ($urandom % 512);
         step("mix", ($urandom % 4) != 0, ($urandom % 10) == 0, $urandom % 16,
              ra, ($urandom % 2) == 1, la);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule